// File: doc/BRIEF.md
# Circular Convolution Engine

This block computes the circular convolution of two signed integer sequences, x and h. Software or an upstream block first loads the samples into two internal buffers through a simple write port. It then pulses a start strobe with the two sequence lengths. The period N is the larger of the two lengths, and the shorter sequence is treated as zero beyond its own length.

At start the engine builds a folded copy of h. Each output is formed by N multiply-accumulate steps, one per clock. The folded copy is then rotated right by one place before the next output. Results leave one word at a time on a valid/ready stream, in index order from 0 to N-1. A one-cycle done pulse follows the last accepted word. Start requests with illegal lengths are refused and flagged.

Top module: `circ_conv`

## Requirements
- R1: When the lengths differ, the shorter sequence is zero beyond its own length. Buffer entries written at or above a sequence's length have no effect on any result.
- R2: A run produces exactly N = max(len_x_i, len_h_i) output words. After that, y_valid_o stays low and busy_o returns low.
- R3: Output word k equals the sum over i in 0..N-1 of x[i]*h[(k-i) mod N], and the words arrive for k = 0, 1, …, N-1. Loading x = 1,2,3,4 and h = 1,2,3 yields 18, 16, 10, 16.
- R4: y_data_o is an exact 40-bit two's complement sum. With every sample of both sequences at -32768 and N = 16, each word is 17179869184.
- R5: Sample writes are accepted only while busy_o is low. A write made during a run changes neither that run nor later runs.
- R6: start_i is accepted only while busy_o is low. A start during a run does not alter the run's outputs or its count, and does not raise err_o.
- R7: While y_valid_o is high and y_ready_i is low, y_valid_o stays high and y_data_o holds its value.
- R8: A start whose length inputs include 0 or a value above 16 raises err_o in the next cycle. Such a start produces no outputs and leaves busy_o low. The next accepted start clears err_o.
- R9: done_o is high for exactly one cycle, in the cycle after the last output word is accepted.
- R10: After reset, busy_o, err_o, y_valid_o and done_o are low.
- R11: A write with wr_sel_i = 0 stores wr_data_i as x[wr_addr_i]. A write with wr_sel_i = 1 stores it as h[wr_addr_i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Sample write strobe |
| wr_sel_i | input | 1 | Target buffer: 0 selects x, 1 selects h |
| wr_addr_i | input | 4 | Sample index |
| wr_data_i | input | 16 | Signed sample value |
| start_i | input | 1 | Start request |
| len_x_i | input | 5 | Length of x, sampled with start_i |
| len_h_i | input | 5 | Length of h, sampled with start_i |
| busy_o | output | 1 | A run is in progress |
| err_o | output | 1 | The last start request carried an illegal length |
| y_data_o | output | 40 | Signed result word |
| y_valid_o | output | 1 | y_data_o holds a result |
| y_ready_i | input | 1 | The consumer accepts the word |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The assertions rely on the consumer keeping y_ready_i at a defined level. They also rely on start_i and wr_en_i never being pulsed in the same cycle. Under those assumptions, a held word and a single-cycle done pulse can be judged from the ports alone.

The bench drives every input on the falling edge and never combines a write with a start. It drops y_ready_i to zero for several cycles on some words, so the hold property is actually exercised. The error path is driven only while the engine is idle.

// File: rtl/circ_conv_pkg.sv
package circ_conv_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned MAX_LEN  = 16;
  localparam int unsigned ACC_W    = 40;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAC,
    ST_OUT
  } cc_state_e;
endpackage

// File: rtl/cconv_xbuf.sv
module cconv_xbuf #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned MAX_LEN  = 16,
  localparam int unsigned IDX_W   = $clog2(MAX_LEN),
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic signed [SAMPLE_W-1:0] wdata_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [IDX_W-1:0]           raddr_i,
  output logic signed [SAMPLE_W-1:0] rdata_o
);
  logic signed [SAMPLE_W-1:0] mem_q [MAX_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '{default: '0};
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // zero padding beyond the sequence length
  assign rdata_o = (LEN_W'(raddr_i) < len_i) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/cconv_hbuf.sv
module cconv_hbuf #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned MAX_LEN  = 16,
  localparam int unsigned IDX_W   = $clog2(MAX_LEN),
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic signed [SAMPLE_W-1:0] wdata_i,
  input  logic                       fold_i,
  input  logic                       rot_i,
  input  logic [LEN_W-1:0]           len_h_i,
  input  logic [LEN_W-1:0]           n_i,
  input  logic [IDX_W-1:0]           raddr_i,
  output logic signed [SAMPLE_W-1:0] rdata_o
);
  logic signed [SAMPLE_W-1:0] h_q    [MAX_LEN];
  logic signed [SAMPLE_W-1:0] a_q    [MAX_LEN];
  logic signed [SAMPLE_W-1:0] fold_d [MAX_LEN];
  logic signed [SAMPLE_W-1:0] rot_d  [MAX_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '{default: '0};
    end else if (we_i) begin
      h_q[waddr_i] <= wdata_i;
    end
  end

  // folded entry j takes h[(N-j) mod N], zero past len_h or past N
  always_comb begin
    for (int j = 0; j < MAX_LEN; j++) begin
      fold_d[j] = '0;
      for (int m = 0; m < MAX_LEN; m++) begin
        if (LEN_W'(j) < n_i && LEN_W'(m) < len_h_i &&
            ((j == 0 && m == 0) || (j != 0 && LEN_W'(m + j) == n_i)))
          fold_d[j] = h_q[m];
      end
    end
  end

  // rotate right by one within the first N entries
  always_comb begin
    rot_d = a_q;
    for (int m = 0; m < MAX_LEN; m++) begin
      if (LEN_W'(m + 1) == n_i) rot_d[0] = a_q[m];
    end
    for (int j = 1; j < MAX_LEN; j++) begin
      if (LEN_W'(j) < n_i) rot_d[j] = a_q[j-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '{default: '0};
    end else if (fold_i) begin
      a_q <= fold_d;
    end else if (rot_i) begin
      a_q <= rot_d;
    end
  end

  assign rdata_o = a_q[raddr_i];
endmodule

// File: rtl/cconv_mac.sv
module cconv_mac #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ACC_W    = 40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic signed [SAMPLE_W-1:0] a_i,
  input  logic signed [SAMPLE_W-1:0] b_i,
  output logic signed [ACC_W-1:0]    acc_o
);
  logic signed [2*SAMPLE_W-1:0] prod;
  logic signed [ACC_W-1:0]      acc_q;

  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + ACC_W'(prod);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/circ_conv.sv
module circ_conv
  import circ_conv_pkg::*;
#(
  parameter int unsigned SAMPLE_W = circ_conv_pkg::SAMPLE_W,
  parameter int unsigned MAX_LEN  = circ_conv_pkg::MAX_LEN,
  parameter int unsigned ACC_W    = circ_conv_pkg::ACC_W,
  localparam int unsigned IDX_W   = $clog2(MAX_LEN),
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [SAMPLE_W-1:0] wr_data_i,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_x_i,
  input  logic [LEN_W-1:0]    len_h_i,
  output logic                busy_o,
  output logic                err_o,
  output logic [ACC_W-1:0]    y_data_o,
  output logic                y_valid_o,
  input  logic                y_ready_i,
  output logic                done_o
);
  cc_state_e               state_q;
  logic [LEN_W-1:0]        n_q, lx_q, n_start, n_sel;
  logic [IDX_W-1:0]        idx_q, k_q;
  logic                    done_q, err_q;
  logic                    idle, len_ok, start_ok, take, last_k, last_i, wr_ok;
  logic signed [SAMPLE_W-1:0] x_rd, a_rd;
  logic signed [ACC_W-1:0] acc;

  assign idle     = (state_q == ST_IDLE);
  assign len_ok   = len_x_i != '0 && len_x_i <= LEN_W'(MAX_LEN) &&
                    len_h_i != '0 && len_h_i <= LEN_W'(MAX_LEN);
  assign start_ok = idle && start_i && len_ok;
  assign n_start  = (len_x_i > len_h_i) ? len_x_i : len_h_i;
  assign n_sel    = idle ? n_start : n_q;
  assign take     = (state_q == ST_OUT) && y_ready_i;
  assign last_k   = LEN_W'(k_q) == n_q - LEN_W'(1);
  assign last_i   = LEN_W'(idx_q) == n_q - LEN_W'(1);
  assign wr_ok    = wr_en_i && idle;

  cconv_xbuf #(.SAMPLE_W(SAMPLE_W), .MAX_LEN(MAX_LEN)) i_xbuf (
    .clk_i, .rst_ni,
    .we_i    (wr_ok && !wr_sel_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .len_i   (lx_q),
    .raddr_i (idx_q),
    .rdata_o (x_rd)
  );

  cconv_hbuf #(.SAMPLE_W(SAMPLE_W), .MAX_LEN(MAX_LEN)) i_hbuf (
    .clk_i, .rst_ni,
    .we_i    (wr_ok && wr_sel_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .fold_i  (start_ok),
    .rot_i   (take && !last_k),
    .len_h_i (len_h_i),
    .n_i     (n_sel),
    .raddr_i (idx_q),
    .rdata_o (a_rd)
  );

  cconv_mac #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) i_mac (
    .clk_i, .rst_ni,
    .clr_i (start_ok || (take && !last_k)),
    .en_i  (state_q == ST_MAC),
    .a_i   (x_rd),
    .b_i   (a_rd),
    .acc_o (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      lx_q    <= '0;
      idx_q   <= '0;
      k_q     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (len_ok) begin
            n_q     <= n_start;
            lx_q    <= len_x_i;
            idx_q   <= '0;
            k_q     <= '0;
            err_q   <= 1'b0;
            state_q <= ST_MAC;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_MAC: begin
          idx_q <= idx_q + 1'b1;
          if (last_i) state_q <= ST_OUT;
        end
        ST_OUT: if (y_ready_i) begin
          k_q   <= k_q + 1'b1;
          idx_q <= '0;
          if (last_k) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_MAC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = !idle;
  assign err_o     = err_q;
  assign y_valid_o = (state_q == ST_OUT);
  assign y_data_o  = acc;
  assign done_o    = done_q;
endmodule

// File: rtl/cconv_chk.sv
module cconv_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             err_o,
  input logic [ACC_W-1:0] y_data_o,
  input logic             y_valid_o,
  input logic             y_ready_i,
  input logic             done_o
);
  a_r7_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |=> (y_valid_o && $stable(y_data_o)));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(y_valid_o && y_ready_i));

  a_r8_err_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!y_valid_o && !busy_o));

  a_r2_word_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> busy_o);

  a_r2_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !y_valid_o));
endmodule

bind circ_conv cconv_chk #(.ACC_W(ACC_W)) i_chk (
  .clk_i, .rst_ni, .busy_o, .err_o, .y_data_o, .y_valid_o, .y_ready_i, .done_o
);

// File: tb/test_circ_conv.sv
module test_circ_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic [4:0]  len_x = '0, len_h = '0;
  logic        busy, err, y_valid, done;
  logic        y_ready = 1'b0;
  logic [39:0] y_data;

  int checks = 0;
  int errors = 0;
  logic signed [15:0] xr [16];
  logic signed [15:0] hr [16];
  longint got [16];

  // per case: len_x, len_h, pattern (0 = ramp 1..n, -1 = all -32768)
  localparam int NCASE = 6;
  localparam int CASES [NCASE][3] = '{
    '{4, 3, 0}, '{3, 5, 1}, '{16, 16, -1}, '{1, 1, 3}, '{16, 7, 2}, '{5, 5, 4}
  };

  always #2 clk = ~clk;

  circ_conv i_circ_conv (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start),
    .len_x_i(len_x), .len_h_i(len_h), .busy_o(busy), .err_o(err),
    .y_data_o(y_data), .y_valid_o(y_valid), .y_ready_i(y_ready), .done_o(done)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_y(int k, int lx, int lh);
    int n = (lx > lh) ? lx : lh;
    longint s = 0;
    for (int i = 0; i < n; i++) begin
      int j = (k - i + n) % n;
      longint xv = (i < lx) ? longint'(xr[i]) : 0;
      longint hv = (j < lh) ? longint'(hr[j]) : 0;
      s += xv * hv;
    end
    return s;
  endfunction

  task automatic wr(bit sel, int addr, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = 4'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int lx, int lh);
    for (int i = 0; i < 16; i++) begin
      wr(1'b0, i, 16'h7abc);   // stale data beyond the length
      wr(1'b1, i, 16'h6543);
    end
    for (int i = 0; i < lx; i++) wr(1'b0, i, xr[i]);
    for (int i = 0; i < lh; i++) wr(1'b1, i, hr[i]);
  endtask

  task automatic kick(int lx, int lh);
    @(negedge clk);
    start = 1'b1; len_x = 5'(lx); len_h = 5'(lh);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(int lx, int lh, bit stall);
    int n = (lx > lh) ? lx : lh;
    for (int k = 0; k < n; k++) begin
      while (!y_valid) @(negedge clk);
      if (stall && k % 2 == 0) begin
        logic [39:0] held = y_data;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check("R7 valid held", longint'(y_valid), 1);
          check("R7 data held", longint'(y_data), longint'(held));
        end
      end
      got[k] = longint'($signed(y_data));
      check("R3 word value", got[k], expect_y(k, lx, lh));
      y_ready = 1'b1;
      @(negedge clk);
      y_ready = 1'b0;
      if (k == n - 1) check("R9 done after last", longint'(done), 1);
    end
    @(negedge clk);
    check("R9 done one cycle", longint'(done), 0);
    check("R2 idle after N words", longint'(busy), 0);
    repeat (5) @(negedge clk);
    check("R2 no extra word", longint'(y_valid), 0);
  endtask

  task automatic fill(int pat);
    for (int i = 0; i < 16; i++) begin
      if (pat == 0) begin
        xr[i] = 16'(i + 1); hr[i] = 16'(i + 1);
      end else if (pat < 0) begin
        xr[i] = -16'sd32768; hr[i] = -16'sd32768;
      end else begin
        xr[i] = 16'((((i * 37 + pat * 11) % 61) - 30) * 500);
        hr[i] = 16'((((i * 23 + pat * 7) % 53) - 26) * 700);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", longint'(busy), 0);
    check("R10 err", longint'(err), 0);
    check("R10 valid", longint'(y_valid), 0);
    check("R10 done", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R11 table walk
    for (int c = 0; c < NCASE; c++) begin
      fill(CASES[c][2]);
      load(CASES[c][0], CASES[c][1]);
      kick(CASES[c][0], CASES[c][1]);
      collect(CASES[c][0], CASES[c][1], c % 2 == 1);
      if (c == 0) begin
        check("R3 y0", got[0], 18);
        check("R3 y1", got[1], 16);
        check("R3 y2", got[2], 10);
        check("R3 y3", got[3], 16);
      end
      if (CASES[c][2] < 0) check("R4 full scale", got[0], 64'sd17179869184);
    end

    // R5 R6 writes and start during a run are ignored
    fill(5);
    load(6, 4);
    kick(6, 4);
    wr(1'b0, 1, 16'sd999);
    wr(1'b1, 0, 16'sd555);
    @(negedge clk);
    start = 1'b1; len_x = 5'd2; len_h = 5'd0;
    @(negedge clk);
    start = 1'b0;
    check("R6 no err while busy", longint'(err), 0);
    collect(6, 4, 1'b0);
    kick(6, 4);
    collect(6, 4, 1'b0);   // buffers untouched, same results

    // R8 illegal lengths
    kick(0, 3);
    check("R8 err zero len", longint'(err), 1);
    check("R8 busy low", longint'(busy), 0);
    repeat (20) @(negedge clk);
    check("R8 no word", longint'(y_valid), 0);
    kick(4, 17);
    check("R8 err long len", longint'(err), 1);
    check("R8 busy low long", longint'(busy), 0);
    kick(6, 4);
    check("R8 err cleared", longint'(err), 0);
    collect(6, 4, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule